// File: doc/BRIEF.md
# Cascadable Codec Serial Port Controller

This block is the host-facing serial port of one codec channel. A single 16-bit shift register carries words in both directions. Because that register is shared, the port is always the master: it makes its own serial clock and frame sync, and it starts every transfer. A transfer starts when the core raises a sample strobe while the port is idle. Words move most significant bit first. The serial clock comes from the pin clock through two dividers: a master-clock divider followed by a power-of-two serial-clock divider.

Each word that arrives is decoded according to the port mode held in control register 0. The word can do one of four things: update the DAC output, write or read one of eight 8-bit control registers, or pass unchanged to the next device in a cascade. Words addressed to another device, and read replies, leave at once in a follow-on frame without waiting for a sample. The core sees each register write through a strobe, and it can read any register through a combinational read port.

Top module: `codec_sport`

## Requirements
- R1: After reset, sclk_o, fs_o, sdo_o, dac_o, dac_stb_o and reg_wr_stb_o are all 0, all eight control registers read 0, the port is in Control mode, and both dividers are at divide-by-1.
- R2: Register 0 bits [1:0] select the mode: bit0 = 0 is Control mode, 01 is Data mode and 11 is Mixed mode. In Data mode every received word, including one with bit 15 set, goes to the DAC and never to a register.
- R3: A sample strobe while idle starts a frame on the next pin clock. A frame is 17 serial-clock slots. Each slot is low for its first half and high for its second. In slot 0 fs_o is high. Slots 1 to 16 put the outgoing word on sdo_o MSB first and capture sdi_i at the rising serial-clock edge.
- R4: On a sample strobe, Data mode loads the register with adc_i and Mixed mode loads it with {0, adc_i[15:1]}. Control mode leaves the register alone, so the last word received goes back out. Strobes that arrive during a frame are ignored.
- R5: A control word has bit15 = 1, bit14 = read (1) or write (0), [13:11] = device address, [10:8] = register index and [7:0] = data. A write whose address matches dev_addr_i updates that register. One pin clock after the frame ends, reg_wr_stb_o pulses, carrying the index and the data.
- R6: A read whose address matches returns {word[15:8], register value} in a new frame that starts as soon as the current one ends.
- R7: A control word for any other device address changes no register. It is sent out unchanged in a new frame that starts as soon as the current one ends.
- R8: A Data-mode word sets dac_o to the whole word. In Mixed mode, a word with bit15 = 0 sets dac_o to {word[14:0], 0}. Either case pulses dac_stb_o for one pin clock. In Control mode, a word with bit15 = 0 is ignored.
- R9: Register 1 bits [3:2] = s set the serial divider to 2^s. Bits [6:4] = m set the master divider to m+1 when m is 0 to 4, and to 1 when m is 5 to 7. A serial-clock period is 2 x master divider x serial divider pin clocks.
- R10: reg_rd_data_o shows the register at index reg_rd_addr_i with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pin clock |
| rst_ni | input | 1 | Active-low reset |
| dev_addr_i | input | 3 | This device's address in the cascade |
| adc_i | input | 16 | Newest ADC sample |
| adc_stb_i | input | 1 | Sample event |
| dac_o | output | 16 | Last DAC word |
| dac_stb_o | output | 1 | DAC word update pulse |
| reg_wr_stb_o | output | 1 | Control register written |
| reg_wr_addr_o | output | 3 | Index of written register |
| reg_wr_data_o | output | 8 | Value written |
| reg_rd_addr_i | input | 3 | Core read index |
| reg_rd_data_o | output | 8 | Core read value |
| sclk_o | output | 1 | Serial clock to host |
| fs_o | output | 1 | Frame sync to host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |

## Verification
A wrong slot count or a bad shift shows up on sdo_o within the same frame, as a misplaced or corrupted bit in the word the host collects. A wrong divider shows up at the second rising serial clock of a frame, as a period that does not match the configuration. A mis-decoded word does its damage one pin clock after the frame ends: an unexpected strobe, a register value the read port shows at once, or a missing or extra follow-on frame, which appears within one serial period.

// File: rtl/codec_sport_pkg.sv
package codec_sport_pkg;
    localparam int WORD_W = 16;
    localparam int DEV_W  = 3;
    localparam int IDX_W  = 3;
    localparam int BYTE_W = 8;
    localparam int MDIV_W = 3;
    localparam int SDIV_W = 2;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_DAC,
        KIND_WRITE,
        KIND_READ,
        KIND_FORWARD
    } word_kind_e;
endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
    parameter int MDIV_W   = 3,
    parameter int SDIV_W   = 2,
    parameter int MDIV_MAX = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [MDIV_W-1:0] mdiv_code_i,
    input  logic [SDIV_W-1:0] sdiv_code_i,
    output logic              tick_o
);
    localparam int MAX_HALF = MDIV_MAX << ((1 << SDIV_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, half_len;

    always_comb begin
        int unsigned mdiv;
        mdiv = (int'(mdiv_code_i) < MDIV_MAX) ? int'(mdiv_code_i) + 1 : 1;
        half_len = CNT_W'(mdiv << sdiv_code_i);
    end

    always_comb begin
        tick_o = run_i && (cnt_q == half_len - 1'b1);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q < half_len));
endmodule

// File: rtl/sport_regfile.sv
module sport_regfile #(
    parameter int NREGS   = 8,
    parameter int IDX_W   = 3,
    parameter int BYTE_W  = 8,
    parameter int MODE_IX = 0,
    parameter int CLK_IX  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rd_a_addr_i,
    output logic [BYTE_W-1:0] rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_addr_i,
    output logic [BYTE_W-1:0] rd_b_data_o,
    output logic [1:0]        mode_o,
    output logic [BYTE_W-1:0] clkcfg_o
);
    logic [BYTE_W-1:0] regs_d [NREGS];
    logic [BYTE_W-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (we_i && (int'(waddr_i) == g)) regs_d[g] = wdata_i;
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) regs_q[g] <= '0;
            else         regs_q[g] <= regs_d[g];
        end
    end

    assign rd_a_data_o = regs_q[rd_a_addr_i];
    assign rd_b_data_o = regs_q[rd_b_addr_i];
    assign mode_o      = regs_q[MODE_IX][1:0];
    assign clkcfg_o    = regs_q[CLK_IX];

    assert_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> (regs_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/sport_word_decode.sv
module sport_word_decode
    import codec_sport_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        mode_i,
    input  logic [DEV_W-1:0]  dev_addr_i,
    output word_kind_e        kind_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [WORD_W-1:0] dac_val_o
);
    localparam int DEV_LO = IDX_W + BYTE_W;
    localparam int RW_BIT = DEV_LO + DEV_W;

    logic ctl_flag, data_only, mixed;

    always_comb begin
        ctl_flag  = word_i[WORD_W-1];
        data_only = mode_i[0] && !mode_i[1];
        mixed     = mode_i[0] && mode_i[1];
        idx_o     = word_i[BYTE_W +: IDX_W];
        dac_val_o = word_i;
        kind_o    = KIND_NONE;
        if (data_only) begin
            kind_o = KIND_DAC;
        end else if (ctl_flag) begin
            if (word_i[DEV_LO +: DEV_W] != dev_addr_i) kind_o = KIND_FORWARD;
            else if (word_i[RW_BIT])                    kind_o = KIND_READ;
            else                                        kind_o = KIND_WRITE;
        end else if (mixed) begin
            kind_o    = KIND_DAC;
            dac_val_o = {word_i[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/codec_sport.sv
module codec_sport
    import codec_sport_pkg::*;
#(
    parameter int NREGS    = 8,
    parameter int MDIV_MAX = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DEV_W-1:0]  dev_addr_i,
    input  logic [WORD_W-1:0] adc_i,
    input  logic              adc_stb_i,
    output logic [WORD_W-1:0] dac_o,
    output logic              dac_stb_o,
    output logic              reg_wr_stb_o,
    output logic [IDX_W-1:0]  reg_wr_addr_o,
    output logic [BYTE_W-1:0] reg_wr_data_o,
    input  logic [IDX_W-1:0]  reg_rd_addr_i,
    output logic [BYTE_W-1:0] reg_rd_data_o,
    output logic              sclk_o,
    output logic              fs_o,
    input  logic              sdi_i,
    output logic              sdo_o
);
    localparam int SLOT_W = $clog2(WORD_W + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_W);
    localparam int MDIV_LO = 2 + SDIV_W;

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic [SLOT_W-1:0] slot;
        logic              rx_bit;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] dac;
        logic              dac_stb;
        logic              wr_stb;
        logic [IDX_W-1:0]  wr_idx;
        logic [BYTE_W-1:0] wr_data;
    } port_state_t;

    port_state_t st_d, st_q;

    logic              tick;
    logic [1:0]        mode;
    logic [BYTE_W-1:0] clkcfg;
    logic [BYTE_W-1:0] reply_byte;
    logic [WORD_W-1:0] word_end;
    word_kind_e        kind;
    logic [IDX_W-1:0]  dec_idx;
    logic [WORD_W-1:0] dac_val;
    logic              rf_we;

    assign word_end = {st_q.shreg[WORD_W-2:0], st_q.rx_bit};

    sport_clkgen #(
        .MDIV_W  (MDIV_W),
        .SDIV_W  (SDIV_W),
        .MDIV_MAX(MDIV_MAX)
    ) i_clkgen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (st_q.active),
        .mdiv_code_i(clkcfg[MDIV_LO +: MDIV_W]),
        .sdiv_code_i(clkcfg[2 +: SDIV_W]),
        .tick_o     (tick)
    );

    sport_regfile #(
        .NREGS (NREGS),
        .IDX_W (IDX_W),
        .BYTE_W(BYTE_W)
    ) i_regfile (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (rf_we),
        .waddr_i    (dec_idx),
        .wdata_i    (word_end[BYTE_W-1:0]),
        .rd_a_addr_i(reg_rd_addr_i),
        .rd_a_data_o(reg_rd_data_o),
        .rd_b_addr_i(dec_idx),
        .rd_b_data_o(reply_byte),
        .mode_o     (mode),
        .clkcfg_o   (clkcfg)
    );

    sport_word_decode i_decode (
        .word_i    (word_end),
        .mode_i    (mode),
        .dev_addr_i(dev_addr_i),
        .kind_o    (kind),
        .idx_o     (dec_idx),
        .dac_val_o (dac_val)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dac_stb = 1'b0;
        st_d.wr_stb  = 1'b0;
        rf_we        = 1'b0;
        if (!st_q.active) begin
            if (adc_stb_i) begin
                st_d.active = 1'b1;
                st_d.sclk   = 1'b0;
                st_d.slot   = '0;
                if (mode == 2'b01)      st_d.shreg = adc_i;
                else if (mode == 2'b11) st_d.shreg = {1'b0, adc_i[WORD_W-1:1]};
            end
        end else if (tick) begin
            if (!st_q.sclk) begin
                st_d.sclk   = 1'b1;
                st_d.rx_bit = sdi_i;
            end else begin
                st_d.sclk = 1'b0;
                if (st_q.slot != '0) st_d.shreg = word_end;
                if (st_q.slot == LAST_SLOT) begin
                    st_d.slot   = '0;
                    st_d.active = 1'b0;
                    unique case (kind)
                        KIND_WRITE: begin
                            rf_we        = 1'b1;
                            st_d.wr_stb  = 1'b1;
                            st_d.wr_idx  = dec_idx;
                            st_d.wr_data = word_end[BYTE_W-1:0];
                        end
                        KIND_READ: begin
                            st_d.shreg  = {word_end[WORD_W-1:BYTE_W], reply_byte};
                            st_d.active = 1'b1;
                        end
                        KIND_FORWARD: st_d.active = 1'b1;
                        KIND_DAC: begin
                            st_d.dac     = dac_val;
                            st_d.dac_stb = 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sclk_o        = st_q.sclk;
    assign fs_o          = st_q.active && (st_q.slot == '0);
    assign sdo_o         = st_q.active && (st_q.slot != '0) && st_q.shreg[WORD_W-1];
    assign dac_o         = st_q.dac;
    assign dac_stb_o     = st_q.dac_stb;
    assign reg_wr_stb_o  = st_q.wr_stb;
    assign reg_wr_addr_o = st_q.wr_idx;
    assign reg_wr_data_o = st_q.wr_data;

    assert_sclk_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && !tick) |=> $stable(sclk_o));
    assert_fs_starts_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fs_o) |-> !sclk_o);
    assert_dac_needs_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_stb_o |-> mode[0]);
    assert_strobe_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({dac_stb_o, reg_wr_stb_o}));
    assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.active |-> (!sclk_o && !fs_o && !sdo_o));
endmodule

// File: tb/test_codec_sport.sv
module test_codec_sport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  dev_addr = 3'd2;
    logic [15:0] adc = '0;
    logic        adc_stb = 1'b0;
    logic [15:0] dac;
    logic        dac_stb, wr_stb;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        sclk, fs, sdi = 1'b0, sdo;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    codec_sport i_codec_sport (
        .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(dev_addr), .adc_i(adc), .adc_stb_i(adc_stb),
        .dac_o(dac), .dac_stb_o(dac_stb), .reg_wr_stb_o(wr_stb), .reg_wr_addr_o(wr_addr),
        .reg_wr_data_o(wr_data), .reg_rd_addr_i(rd_addr), .reg_rd_data_o(rd_data),
        .sclk_o(sclk), .fs_o(fs), .sdi_i(sdi), .sdo_o(sdo)
    );

    // host model
    logic [15:0] tx_plan [0:511];
    logic [15:0] got [0:511];
    logic [15:0] cur_tx, rxw, last_dac;
    logic        prev_sclk = 1'b0, prev_fs = 1'b0, in_frame = 1'b0;
    int nbit = 0, frame_cnt = 0, last_rise = 0, period = 0, fs_rise_cyc = 0;
    int dac_cnt = 0, wr_cnt = 0, stb_cyc = 0;
    logic [2:0]  last_wa;
    logic [7:0]  last_wd;

    initial for (int i = 0; i < 512; i++) tx_plan[i] = '0;

    always @(negedge clk) begin
        if (fs && !prev_fs) fs_rise_cyc = cyc;
        if (sclk && !prev_sclk) begin
            if (fs) begin
                in_frame = 1'b1; nbit = 0; rxw = '0; last_rise = cyc;
                cur_tx = tx_plan[frame_cnt];
            end else if (in_frame) begin
                period = cyc - last_rise; last_rise = cyc;
                rxw = {rxw[14:0], sdo}; nbit++;
                if (nbit == 16) begin
                    got[frame_cnt] = rxw; frame_cnt++; in_frame = 1'b0;
                end
            end
        end
        if (!sclk && prev_sclk) sdi = (in_frame && nbit < 16) ? cur_tx[15-nbit] : 1'b0;
        if (dac_stb) begin dac_cnt++; last_dac = dac; end
        if (wr_stb) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
        prev_sclk = sclk; prev_fs = fs;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(input logic rw, input logic [2:0] d, input logic [2:0] r,
                                       input logic [7:0] v);
        return {1'b1, rw, d, r, v};
    endfunction

    task automatic fire(input logic [15:0] v);
        @(negedge clk); adc = v; adc_stb = 1'b1; stb_cyc = cyc;
        @(negedge clk); adc_stb = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int tgt = frame_cnt + n;
        while (frame_cnt < tgt) @(negedge clk);
        repeat (100) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); rd_addr = a; #1; v = rd_data;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++; $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int f0, d0, w0;
        do_reset;
        // R1 reset state
        check("R1 sclk", {15'd0, sclk}, 0); check("R1 fs", {15'd0, fs}, 0);
        check("R1 sdo", {15'd0, sdo}, 0);   check("R1 dac", dac, 0);
        check("R1 strobes", {14'd0, dac_stb, wr_stb}, 0);
        for (int a = 0; a < 8; a++) begin rd_reg(3'(a), v); check("R1 reg", {8'd0, v}, 0); end

        // R5 write in control mode; R4 control mode sends retained zero
        tx_plan[frame_cnt] = cw(0, 3'd2, 3'd5, 8'hA5);
        fire(16'hFFFF); wait_frames(1);
        check("R4 ctl retain", got[frame_cnt-1], 16'h0000);
        check("R5 wr count", 16'(wr_cnt), 1);
        check("R5 wr addr/data", {5'd0, last_wa, last_wd}, {5'd0, 3'd5, 8'hA5});
        rd_reg(3'd5, v); check("R10 read port", {8'd0, v}, 16'h00A5);
        check("R9 default period", 16'(period), 2);

        // R6 read reply in follow-on frame; echo of prior word (R4)
        tx_plan[frame_cnt] = cw(1, 3'd2, 3'd5, 8'h00);
        fire(16'h0000); wait_frames(2);
        check("R4 ctl echo", got[frame_cnt-2], 16'h95A5);
        check("R6 read reply", got[frame_cnt-1], 16'hD5A5);

        // R7 forwarding
        w0 = wr_cnt;
        tx_plan[frame_cnt] = cw(0, 3'd5, 3'd3, 8'h3C);
        fire(16'h0000); wait_frames(2);
        check("R7 forwarded word", got[frame_cnt-1], 16'hAB3C);
        check("R7 no write", 16'(wr_cnt - w0), 0);
        rd_reg(3'd3, v); check("R7 reg untouched", {8'd0, v}, 0);

        // R8 control mode ignores flag-0 words
        f0 = frame_cnt;
        tx_plan[frame_cnt] = 16'h1234;
        fire(16'h0000); wait_frames(1); repeat (200) @(negedge clk);
        check("R8 ctl ignore dac", 16'(dac_cnt), 0);
        check("R8 ctl ignore wr", 16'(wr_cnt - w0), 0);
        check("R8 ctl no extra frame", 16'(frame_cnt - f0), 1);

        // R9 clock sweep: frame k writes cfg k, frame k+1 measures it
        for (int k = 0; k <= 32; k++) begin
            logic [7:0] cfgv;
            cfgv = (k < 32) ? {1'b0, 3'(k / 4), 2'(k % 4), 2'b00} : 8'h00;
            tx_plan[frame_cnt] = cw(0, 3'd2, 3'd1, cfgv);
            fire(16'h0000); wait_frames(1);
            if (k > 0) begin
                int m, s;
                m = ((k - 1) / 4 < 5) ? (k - 1) / 4 + 1 : 1;
                s = 1 << ((k - 1) % 4);
                check("R9 sclk period", 16'(period), 16'(2 * m * s));
            end
        end

        // R2 switch to Data mode
        tx_plan[frame_cnt] = cw(0, 3'd2, 3'd0, 8'h01);
        fire(16'h0000); wait_frames(1);
        rd_reg(3'd0, v); check("R2 mode reg", {8'd0, v}, 16'h0001);

        // R4/R8/R3 data patterns
        for (int k = 0; k < 8; k++) begin
            logic [15:0] a, h;
            a = 16'hBEEF ^ 16'(k * 16'h1357);
            h = 16'h1234 + 16'(k * 16'h0F1E);
            d0 = dac_cnt;
            tx_plan[frame_cnt] = h;
            fire(a); wait_frames(1);
            check("R3 fs latency", 16'(fs_rise_cyc - stb_cyc), 1);
            check("R4 data out", got[frame_cnt-1], a);
            check("R8 data dac", last_dac, h);
            check("R8 dac strobe", 16'(dac_cnt - d0), 1);
        end
        w0 = wr_cnt;
        tx_plan[frame_cnt] = 16'h95A5;
        fire(16'h0001); wait_frames(1);
        check("R2 data takes flag word", last_dac, 16'h95A5);
        check("R2 data no write", 16'(wr_cnt - w0), 0);

        // R4 strobe during frame ignored
        f0 = frame_cnt;
        fire(16'h0F0F); repeat (10) @(negedge clk);
        fire(16'hFFFF); wait_frames(1); repeat (200) @(negedge clk);
        check("R4 drop mid-frame", got[frame_cnt-1], 16'h0F0F);
        check("R4 single frame", 16'(frame_cnt - f0), 1);

        // Mixed mode
        do_reset;
        tx_plan[frame_cnt] = cw(0, 3'd2, 3'd0, 8'h03);
        fire(16'h0000); wait_frames(1);
        for (int k = 0; k < 4; k++) begin
            logic [15:0] a, h;
            a = 16'hBEEF + 16'(k * 16'h2222);
            h = {1'b0, 15'(16'h2345 + k * 16'h0321)};
            tx_plan[frame_cnt] = h;
            fire(a); wait_frames(1);
            check("R4 mixed out", got[frame_cnt-1], {1'b0, a[15:1]});
            check("R8 mixed dac", last_dac, {h[14:0], 1'b0});
        end
        tx_plan[frame_cnt] = cw(0, 3'd2, 3'd6, 8'h77);
        fire(16'h0000); wait_frames(1);
        rd_reg(3'd6, v); check("R2 mixed ctl write", {8'd0, v}, 16'h0077);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule